// File: doc/BRIEF.md
# Comparator edge debounce filter

This block sits behind a single-bit analog comparator output and turns it into a clean, sticky event flag that can drive an interrupt. The raw bit passes through a two-flop synchronizer first. The filtered result then sets `evt_flag`, which stays high until software pulses `flag_clr`. `irq` is a one-cycle pulse on each confirmation. The only timing reference is `ovf_tick`, a one-cycle pulse from a free-running external timer. The filter keeps no period counter of its own. The timer period is the tuning knob.

The filter has three sampling behaviours. With `clk_sel` at 00 and `dbnc_en` low, the synchronized level is compared every clock and a qualifying edge is reported at once. With `clk_sel` at 00 and `dbnc_en` high, a qualifying edge arms a confirmation. The filter counts two overflow ticks, then resamples the level. A match with the new level sets the flag and a mismatch drops the event. Because the timer runs freely, this places the flag between one and two timer periods after the edge. With `clk_sel` nonzero, the level is sampled only on overflow ticks, and a change is accepted only after four consecutive tick samples at the new level.

`edge_sel` chooses which transitions count. It can also put the block in a level mode that bypasses all filtering.

Top module: `cmp_edge_filter`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, `evt_flag` and `irq` are 0 and the reference level is loaded from the synchronized input, so a steady high input gives no event after reset even with rising edges selected.
- R2: With `clk_sel`=00 and `dbnc_en`=0, a qualifying change on `cmp_raw` sets `evt_flag` and `irq` at the third rising clock edge after the change (two synchronizer stages plus one register).
- R3: `edge_sel` encoding: 00 accepts only falling transitions, 01 only rising, 10 both; a transition of the other direction never sets the flag.
- R4: With `edge_sel`=11 (level mode), the flag is set and `irq` is high on every cycle in which the synchronized input is 1, whatever `clk_sel` and `dbnc_en` hold.
- R5: With `clk_sel`=00 and `dbnc_en`=1, a qualifying edge does not set the flag at once. The level is resampled at the second `ovf_tick` after detection, and the flag is set at that tick's clock edge if the level equals the new level.
- R6: If the level resampled at the second tick differs from the level expected after the edge, the event is dropped and the flag stays 0.
- R7: While the confirmation wait is running, further transitions are ignored. After the resample decision the detector re-arms and a fresh qualifying edge starts a new wait.
- R8: With `clk_sel` nonzero, the input is sampled only on `ovf_tick`. A change is accepted (and, if it qualifies, sets the flag) on the fourth consecutive tick sample at the new level. A tick sample back at the old level restarts the count.
- R9: With `clk_sel` nonzero, `dbnc_en` has no effect: two ticks after an edge do not set the flag.
- R10: `evt_flag` stays set until a one-cycle `flag_clr`. When a clear and a new confirmation fall in the same cycle, the flag ends up set.
- R11: `irq` is high for exactly one cycle per confirmation, at the same clock edge at which `evt_flag` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| ovf_tick | input | 1 | One-cycle overflow pulse from the free-running timer |
| clk_sel | input | 2 | Sample clock select: 00 every clock, nonzero tick-rate sampling |
| edge_sel | input | 2 | 00 falling, 01 rising, 10 either edge, 11 level mode |
| dbnc_en | input | 1 | Enables two-tick delayed resample confirmation when `clk_sel` is 00 |
| flag_clr | input | 1 | One-cycle clear of the event flag |
| evt_flag | output | 1 | Sticky confirmed-event flag |
| irq | output | 1 | One-cycle interrupt request on each confirmation |

## Verification
In per-clock mode, a level change on `cmp_raw` reaches `evt_flag` and `irq` three clock edges later. The bench therefore holds each table vector for a stated number of cycles and samples at the falling edge after the last of them. In both tick-driven modes, results come due on the clock edge that carries the deciding `ovf_tick`. The bench drives each tick for exactly one cycle and checks right after that edge, and it also checks after the earlier ticks to show the flag is not yet set. `irq` is checked one cycle after a confirmation to confirm that it falls while the flag stays.

// File: rtl/cef_pkg.sv
package cef_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL  = 2'b00,
        EDGE_RISE  = 2'b01,
        EDGE_ANY   = 2'b10,
        EDGE_LEVEL = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        MODE_CLOCK    = 2'b00,
        MODE_RESAMPLE = 2'b01,
        MODE_PERSIST  = 2'b10
    } filt_mode_e;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_WAIT = 1'b1
    } wait_st_e;

endpackage

// File: rtl/cef_sync.sv
module cef_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) chain_q <= d;
        end else begin : g_many
            always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], d};
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cef_mode_dec.sv
module cef_mode_dec
    import cef_pkg::*;
(
    input  logic [1:0]  clk_sel,
    input  logic        dbnc_en,
    output filt_mode_e  mode
);
    always_comb begin
        if (clk_sel != 2'b00)  mode = MODE_PERSIST;
        else if (dbnc_en)      mode = MODE_RESAMPLE;
        else                   mode = MODE_CLOCK;
    end
endmodule

// File: rtl/cef_edge_qual.sv
module cef_edge_qual
    import cef_pkg::*;
(
    input  logic       prev_lvl,
    input  logic       cur_lvl,
    input  logic [1:0] edge_sel,
    output logic       hit,
    output logic       level_on,
    output logic       level_mode
);
    edge_sel_e sel;

    always_comb begin
        sel        = edge_sel_e'(edge_sel);
        level_mode = (sel == EDGE_LEVEL);
        level_on   = level_mode & cur_lvl;
        unique case (sel)
            EDGE_FALL: hit = prev_lvl & ~cur_lvl;
            EDGE_RISE: hit = ~prev_lvl & cur_lvl;
            EDGE_ANY:  hit = prev_lvl ^ cur_lvl;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_edge_filter.sv
module cmp_edge_filter
    import cef_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OVF_TICKS   = 2,
    parameter int PERSIST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmp_raw,
    input  logic       ovf_tick,
    input  logic [1:0] clk_sel,
    input  logic [1:0] edge_sel,
    input  logic       dbnc_en,
    input  logic       flag_clr,
    output logic       evt_flag,
    output logic       irq
);
    localparam int OCW = $clog2(OVF_TICKS + 1);
    localparam int PCW = $clog2(PERSIST_LEN + 1);
    localparam logic [OCW-1:0] OCNT_LAST = OCW'(OVF_TICKS - 1);
    localparam logic [PCW-1:0] PCNT_LAST = PCW'(PERSIST_LEN - 1);

    typedef struct packed {
        logic           ref_lvl;
        wait_st_e       wst;
        logic           exp_lvl;
        logic [OCW-1:0] ocnt;
        logic [PCW-1:0] pcnt;
        logic           flag;
        logic           irq;
    } state_t;

    state_t     st_d, st_q;
    logic       cur_lvl;
    logic       hit;
    logic       level_on;
    logic       level_mode;
    logic       set_evt;
    filt_mode_e mode;

    cef_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (cmp_raw),
        .q   (cur_lvl)
    );

    cef_mode_dec u_mode (
        .clk_sel (clk_sel),
        .dbnc_en (dbnc_en),
        .mode    (mode)
    );

    cef_edge_qual u_qual (
        .prev_lvl   (st_q.ref_lvl),
        .cur_lvl    (cur_lvl),
        .edge_sel   (edge_sel),
        .hit        (hit),
        .level_on   (level_on),
        .level_mode (level_mode)
    );

    always_comb begin
        st_d    = st_q;
        set_evt = 1'b0;
        if (rst) begin
            st_d.ref_lvl = cur_lvl;
            st_d.exp_lvl = cur_lvl;
            st_d.wst     = WS_IDLE;
            st_d.ocnt    = '0;
            st_d.pcnt    = '0;
            st_d.flag    = 1'b0;
            st_d.irq     = 1'b0;
        end else begin
            if (level_mode) begin
                // no filtering: track the level directly
                set_evt      = level_on;
                st_d.ref_lvl = cur_lvl;
                st_d.wst     = WS_IDLE;
                st_d.ocnt    = '0;
                st_d.pcnt    = '0;
            end else begin
                unique case (mode)
                    MODE_CLOCK: begin
                        set_evt      = hit;
                        st_d.ref_lvl = cur_lvl;
                        st_d.wst     = WS_IDLE;
                        st_d.ocnt    = '0;
                        st_d.pcnt    = '0;
                    end
                    MODE_RESAMPLE: begin
                        st_d.pcnt = '0;
                        if (st_q.wst == WS_IDLE) begin
                            if (hit) begin
                                st_d.wst     = WS_WAIT;
                                st_d.exp_lvl = cur_lvl;
                                st_d.ocnt    = '0;
                            end else begin
                                st_d.ref_lvl = cur_lvl;
                            end
                        end else if (ovf_tick) begin
                            if (st_q.ocnt == OCNT_LAST) begin
                                // resample decision, then re-arm
                                set_evt      = (cur_lvl == st_q.exp_lvl);
                                st_d.ref_lvl = cur_lvl;
                                st_d.wst     = WS_IDLE;
                                st_d.ocnt    = '0;
                            end else begin
                                st_d.ocnt = st_q.ocnt + OCW'(1);
                            end
                        end
                    end
                    MODE_PERSIST: begin
                        st_d.wst  = WS_IDLE;
                        st_d.ocnt = '0;
                        if (ovf_tick) begin
                            if (cur_lvl != st_q.ref_lvl) begin
                                if (st_q.pcnt == PCNT_LAST) begin
                                    set_evt      = hit;
                                    st_d.ref_lvl = cur_lvl;
                                    st_d.pcnt    = '0;
                                end else begin
                                    st_d.pcnt = st_q.pcnt + PCW'(1);
                                end
                            end else begin
                                st_d.pcnt = '0;
                            end
                        end
                    end
                    default: begin
                        st_d.wst = WS_IDLE;
                    end
                endcase
            end
            st_d.flag = set_evt | (st_q.flag & ~flag_clr);
            st_d.irq  = set_evt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign evt_flag = st_q.flag;
    assign irq      = st_q.irq;
endmodule

// File: rtl/cef_checker.sv
module cef_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmp_raw,
    input logic       ovf_tick,
    input logic [1:0] clk_sel,
    input logic [1:0] edge_sel,
    input logic       dbnc_en,
    input logic       flag_clr,
    input logic       evt_flag,
    input logic       irq
);
    logic [4:0] cfg_prev_q;
    logic [2:0] calm_q;
    logic [4:0] cfg_now;

    assign cfg_now = {clk_sel, edge_sel, dbnc_en};

    // cycles since reset with unchanged configuration, saturating
    always_ff @(posedge clk) begin
        cfg_prev_q <= cfg_now;
        if (rst || cfg_now != cfg_prev_q) calm_q <= '0;
        else if (calm_q != 3'd7)          calm_q <= calm_q + 3'd1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!evt_flag && !irq));

    a_r11_irq_has_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> evt_flag);

    a_r11_flag_rise_irq: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_flag) |-> irq);

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (evt_flag && !flag_clr) |=> evt_flag);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (evt_flag && flag_clr) |=> (!evt_flag || irq));

    // R2: rising edge seen three clocks back raises irq now
    a_r2_clock_edge: assert property (@(posedge clk) disable iff (rst)
        (calm_q >= 3'd6 && cfg_prev_q == 5'b00010
         && $past(cmp_raw, 3) && !$past(cmp_raw, 4)) |-> irq);

    a_r4_level_follow: assert property (@(posedge clk) disable iff (rst)
        (calm_q >= 3'd3 && cfg_prev_q[2:1] == 2'b11) |-> (irq == $past(cmp_raw, 3)));

    a_r5_resample_tick: assert property (@(posedge clk) disable iff (rst)
        (calm_q >= 3'd1 && cfg_prev_q[4:3] == 2'b00 && cfg_prev_q[0]
         && cfg_prev_q[2:1] != 2'b11 && irq) |-> $past(ovf_tick));

    a_r8_persist_tick: assert property (@(posedge clk) disable iff (rst)
        (calm_q >= 3'd1 && cfg_prev_q[4:3] != 2'b00
         && cfg_prev_q[2:1] != 2'b11 && irq) |-> $past(ovf_tick));
endmodule

bind cmp_edge_filter cef_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmp_raw  (cmp_raw),
    .ovf_tick (ovf_tick),
    .clk_sel  (clk_sel),
    .edge_sel (edge_sel),
    .dbnc_en  (dbnc_en),
    .flag_clr (flag_clr),
    .evt_flag (evt_flag),
    .irq      (irq)
);

// File: tb/sim_cmp_edge_filter.sv
module sim_cmp_edge_filter;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmp_raw;
    logic       ovf_tick;
    logic [1:0] clk_sel;
    logic [1:0] edge_sel;
    logic       dbnc_en;
    logic       flag_clr;
    logic       evt_flag;
    logic       irq;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // {edge_sel, raw, clr, hold cycles, exp flag, exp irq}
    localparam bit [9:0] VEC [NVEC] = '{
        {2'b01, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0},  // R2 not yet through sync
        {2'b01, 1'b1, 1'b0, 4'd1, 1'b1, 1'b1},  // R2 third edge
        {2'b01, 1'b1, 1'b0, 4'd1, 1'b1, 1'b0},  // R11 pulse ends, R10 sticky
        {2'b01, 1'b1, 1'b1, 4'd1, 1'b0, 1'b0},  // R10 clear
        {2'b01, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0},  // R3 fall ignored on rise
        {2'b00, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0},  // R3 rise ignored on fall
        {2'b00, 1'b0, 1'b0, 4'd3, 1'b1, 1'b1},  // R3 falling
        {2'b00, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0},  // R10 clear
        {2'b10, 1'b1, 1'b0, 4'd3, 1'b1, 1'b1},  // R3 any, rising
        {2'b10, 1'b1, 1'b1, 4'd1, 1'b0, 1'b0},  // R10 clear
        {2'b10, 1'b0, 1'b0, 4'd3, 1'b1, 1'b1},  // R3 any, falling
        {2'b11, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0},  // R4 level low
        {2'b11, 1'b1, 1'b1, 4'd3, 1'b1, 1'b1},  // R4 / R10 set beats clear
        {2'b11, 1'b1, 1'b1, 4'd2, 1'b1, 1'b1},  // R4 still high
        {2'b11, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0},  // R4 level dropped
        {2'b11, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0}   // R4 stays low
    };
    localparam string VTAG [NVEC] = '{
        "R2", "R2", "R11", "R10", "R3", "R3", "R3", "R10",
        "R3", "R10", "R3", "R4", "R4", "R4", "R4", "R4"
    };

    cmp_edge_filter u0 (
        .clk      (clk),
        .rst      (rst),
        .cmp_raw  (cmp_raw),
        .ovf_tick (ovf_tick),
        .clk_sel  (clk_sel),
        .edge_sel (edge_sel),
        .dbnc_en  (dbnc_en),
        .flag_clr (flag_clr),
        .evt_flag (evt_flag),
        .irq      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic tick();
        ovf_tick = 1'b1;
        cyc(1);
        ovf_tick = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
    endtask

    task automatic chk(input string tag, input logic ef, input logic ei);
        checks++;
        if (evt_flag !== ef || irq !== ei) begin
            errors++;
            $display("FAIL %s: flag/irq actual %b/%b expected %b/%b at %0t",
                     tag, evt_flag, irq, ef, ei, $time);
        end
    endtask

    initial begin
        rst = 1'b1; cmp_raw = 1'b0; ovf_tick = 1'b0; clk_sel = 2'b00;
        edge_sel = 2'b01; dbnc_en = 1'b0; flag_clr = 1'b0;
        cyc(4);
        chk("R1", 1'b0, 1'b0);
        rst = 1'b0;

        // table of per-clock and level-mode vectors
        for (int i = 0; i < NVEC; i++) begin
            edge_sel = VEC[i][9:8];
            cmp_raw  = VEC[i][7];
            flag_clr = VEC[i][6];
            cyc(int'(VEC[i][5:2]));
            flag_clr = 1'b0;
            chk(VTAG[i], VEC[i][1], VEC[i][0]);
        end

        // R1: reset while high loads the reference, no spurious rise
        edge_sel = 2'b11; cmp_raw = 1'b1; cyc(3);
        chk("R4", 1'b1, 1'b1);
        rst = 1'b1; edge_sel = 2'b01; cyc(3);
        chk("R1", 1'b0, 1'b0);
        rst = 1'b0; cyc(4);
        chk("R1", 1'b0, 1'b0);
        cmp_raw = 1'b0; cyc(4);
        cmp_raw = 1'b1; cyc(3);
        chk("R2", 1'b1, 1'b1);
        clear_flag();

        // R5: delayed resample, accepted on second tick
        dbnc_en = 1'b1;
        cmp_raw = 1'b0; cyc(4);
        cmp_raw = 1'b1; cyc(3);
        chk("R5", 1'b0, 1'b0);
        cyc(5); tick();
        chk("R5", 1'b0, 1'b0);
        cyc(5); tick();
        chk("R5", 1'b1, 1'b1);
        cyc(1);
        chk("R11", 1'b1, 1'b0);
        clear_flag();

        // R6: level back low at resample, event dropped
        cmp_raw = 1'b0; cyc(4);
        cmp_raw = 1'b1; cyc(3);
        cmp_raw = 1'b0; cyc(3);
        tick(); cyc(2); tick();
        chk("R6", 1'b0, 1'b0);

        // R7: glitch during wait ignored, then re-arm
        cmp_raw = 1'b1; cyc(3);
        cmp_raw = 1'b0; cyc(3);
        cmp_raw = 1'b1; cyc(3);
        tick(); cyc(2); tick();
        chk("R7", 1'b1, 1'b1);
        clear_flag();
        cmp_raw = 1'b0; cyc(4);
        cmp_raw = 1'b1; cyc(3);
        tick(); tick();
        chk("R7", 1'b1, 1'b1);
        clear_flag();

        // R8 / R9: tick-rate persistence, debounce enable ignored
        clk_sel = 2'b01;
        cmp_raw = 1'b0; cyc(3);
        for (int t = 0; t < 4; t++) tick();
        chk("R8", 1'b0, 1'b0);
        cmp_raw = 1'b1; cyc(3);
        chk("R8", 1'b0, 1'b0);
        tick(); tick();
        chk("R9", 1'b0, 1'b0);
        tick();
        chk("R8", 1'b0, 1'b0);
        tick();
        chk("R8", 1'b1, 1'b1);
        clear_flag();

        // R8: a sample back at the old level restarts the count
        clk_sel = 2'b11;
        cmp_raw = 1'b0; cyc(3);
        for (int t = 0; t < 4; t++) tick();
        cmp_raw = 1'b1; cyc(3);
        tick(); tick();
        cmp_raw = 1'b0; cyc(3);
        tick();
        cmp_raw = 1'b1; cyc(3);
        for (int t = 0; t < 3; t++) tick();
        chk("R8", 1'b0, 1'b0);
        tick();
        chk("R8", 1'b1, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule